// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit with Carry

This block performs one single-bit shift, rotate or bitwise inversion on a byte, word or long operand and produces the new operand together with the negative, zero, overflow and carry condition flags. It is meant to sit in the execute stage of a small integer core. There it takes the operand, an operation code, a size code and the current carry flag. It hands back the result and flags one clock later.

The operand is first cut down to the selected size. The single-step operation is then applied within that width: the size-dependent top bit takes the part of a sign bit, a carry source or a rotate target. Bits above the selected width are always returned as zero. The two rotates through carry treat the incoming carry as one extra bit just beyond the operand. There are eight shift and rotate variants and one inversion, each selected by a 4-bit code. Multi-bit shift counts, register storage and instruction decode live elsewhere.

Top module: `shrot_unit`

## Requirements
- R1: While rst_ni is low, result_o, n_o, z_o, v_o and c_o are all zero.
- R2: The result and the flags for the inputs present at a rising clock edge appear on the outputs right after that edge and hold until the next edge.
- R3: size_i selects the operand width: 0 is 8 bits, 1 is 16 bits, 2 and 3 are 32 bits. Input bits above the width are ignored, and result_o bits above the width are zero.
- R4: Op codes 0 (logical left) and 2 (arithmetic left) shift the sized operand one place left, fill bit 0 with zero and put the old top bit into C.
- R5: Op code 1 (logical right) shifts one place right, fills the top bit with zero and puts the old bit 0 into C.
- R6: Op code 3 (arithmetic right) shifts one place right, keeps the old top bit in the top position and puts the old bit 0 into C.
- R7: Op code 4 (rotate left) moves the old top bit into both bit 0 and C. Op code 5 (rotate right) moves the old bit 0 into both the top bit and C.
- R8: Op code 6 (rotate left through carry) places carry_i in bit 0 and the old top bit in C. Op code 7 (rotate right through carry) places carry_i in the top bit and the old bit 0 in C.
- R9: Op code 8 inverts every bit of the sized operand and returns C equal to carry_i.
- R10: Op codes 9 to 15 return the sized operand unchanged and C equal to carry_i.
- R11: N equals the top bit of the sized result. Z is 1 exactly when the sized result is zero.
- R12: V is 0 after every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size code |
| operand_i | input | 32 | Operand value |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Sized result, upper bits zero |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |

## Verification
Every operation code is run at all three sizes, with each of these operands:
- a value whose top and bottom bits are both set, which shows whether the carry is taken from the correct end;
- a value whose top bit is clear but whose bits above the selected size are set, which exposes a wrong mask or a wrong top-bit position;
- an all-zero value and a single-bit value that shifts out to zero, which separate the zero and negative flag logic from the data path.

Each case is tried with carry_i at both 0 and 1. This shows that only the through-carry rotates, the inversion and the reserved codes read the incoming carry, and that only the latter two pass it through unchanged. Size code 3 is checked against size code 2.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned SIZE_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_SHL_LOG = 4'd0,
    OP_SHR_LOG = 4'd1,
    OP_SHL_ARI = 4'd2,
    OP_SHR_ARI = 4'd3,
    OP_ROL     = 4'd4,
    OP_ROR     = 4'd5,
    OP_ROL_C   = 4'd6,
    OP_ROR_C   = 4'd7,
    OP_INV     = 4'd8
  } shrot_op_e;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } shrot_size_e;
endpackage

// File: rtl/shrot_mask.sv
module shrot_mask
  import shrot_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] top_o
);
  localparam int unsigned NUM_SZ = 3;

  logic [NUM_SZ-1:0][DATA_W-1:0] mask_tab;
  logic [NUM_SZ-1:0][DATA_W-1:0] top_tab;

  // width of entry k is DATA_W >> (2-k): quarter, half, full
  for (genvar k = 0; k < NUM_SZ; k++) begin : g_size
    localparam int unsigned SZ_BITS = DATA_W >> (NUM_SZ - 1 - k);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign mask_tab[k][b] = (b < SZ_BITS);
      assign top_tab[k][b]  = (b == SZ_BITS - 1);
    end
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin mask_o = mask_tab[0]; top_o = top_tab[0]; end
      SZ_WORD: begin mask_o = mask_tab[1]; top_o = top_tab[1]; end
      default: begin mask_o = mask_tab[2]; top_o = top_tab[2]; end
    endcase
  end
endmodule

// File: rtl/shrot_datapath.sv
module shrot_datapath
  import shrot_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] top_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  logic [DATA_W-1:0] sized, left, right, top_if_msb, top_if_lsb, top_if_cin;
  logic              msb, lsb;

  always_comb begin
    sized      = operand_i & mask_i;
    msb        = |(sized & top_i);
    lsb        = sized[0];
    left       = (sized << 1) & mask_i;
    right      = sized >> 1;
    top_if_msb = msb     ? top_i : '0;
    top_if_lsb = lsb     ? top_i : '0;
    top_if_cin = carry_i ? top_i : '0;

    result_o = sized;
    carry_o  = carry_i;
    case (op_i)
      OP_SHL_LOG, OP_SHL_ARI: begin result_o = left;                        carry_o = msb; end
      OP_SHR_LOG:             begin result_o = right;                       carry_o = lsb; end
      OP_SHR_ARI:             begin result_o = right | top_if_msb;          carry_o = lsb; end
      OP_ROL:                 begin result_o = left | DATA_W'(msb);         carry_o = msb; end
      OP_ROR:                 begin result_o = right | top_if_lsb;          carry_o = lsb; end
      OP_ROL_C:               begin result_o = left | DATA_W'(carry_i);     carry_o = msb; end
      OP_ROR_C:               begin result_o = right | top_if_cin;          carry_o = lsb; end
      OP_INV:                 begin result_o = ~sized & mask_i;             carry_o = carry_i; end
      default:                ; // reserved: pass sized operand, keep carry
    endcase
  end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic [DATA_W-1:0] top_i,
  output logic              neg_o,
  output logic              zero_o,
  output logic              ovf_o
);
  assign neg_o  = |(result_i & top_i);
  assign zero_o = (result_i == '0);
  assign ovf_o  = 1'b0;
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o
);
  localparam int unsigned BYTE_W = DATA_W / 4;

  logic [DATA_W-1:0] mask, top, res_d;
  logic              c_d, n_d, z_d, v_d;
  logic              live_q;

  shrot_mask #(.DATA_W(DATA_W)) u_mask (
    .size_i (size_i),
    .mask_o (mask),
    .top_o  (top)
  );

  shrot_datapath #(.DATA_W(DATA_W)) u_dp (
    .op_i      (op_i),
    .operand_i (operand_i),
    .mask_i    (mask),
    .top_i     (top),
    .carry_i   (carry_i),
    .result_o  (res_d),
    .carry_o   (c_d)
  );

  shrot_flags #(.DATA_W(DATA_W)) u_flags (
    .result_i (res_d),
    .top_i    (top),
    .neg_o    (n_d),
    .zero_o   (z_d),
    .ovf_o    (v_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      n_o      <= 1'b0;
      z_o      <= 1'b0;
      v_o      <= 1'b0;
      c_o      <= 1'b0;
      live_q   <= 1'b0;
    end else begin
      result_o <= res_d;
      n_o      <= n_d;
      z_o      <= z_d;
      v_o      <= v_d;
      c_o      <= c_d;
      live_q   <= 1'b1;
    end
  end

  // R3
  byte_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(size_i) == SZ_BYTE) |-> (result_o[DATA_W-1:BYTE_W] == '0));

  // R11
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (z_o == (result_o == '0)));

  // R12
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> !v_o);

  // R4
  shl_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(size_i) == SZ_BYTE && $past(op_i) == OP_SHL_LOG)
      |-> (c_o == $past(operand_i[BYTE_W-1]) && !result_o[0]));

  // R9
  inv_keeps_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(op_i) == OP_INV) |-> (c_o == $past(carry_i)));

  // R7
  rol_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(op_i) == OP_ROL) |-> (result_o[0] == c_o));
endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] operand_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        n_o, z_o, v_o, c_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk_i = ~clk_i;

  shrot_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .size_i(size_i),
    .operand_i(operand_i), .carry_i(carry_i), .result_o(result_o),
    .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference model from the requirements
  task automatic model(input logic [3:0] op, input logic [1:0] sz,
                       input logic [31:0] x, input logic cin,
                       output logic [31:0] r, output logic c);
    int w;
    logic [31:0] v;
    logic hi, lo;
    w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    v  = '0;
    for (int i = 0; i < w; i++) v[i] = x[i];
    hi = v[w-1];
    lo = v[0];
    r  = v;
    c  = cin;
    case (op)
      4'd0, 4'd2: begin r = v << 1; c = hi; end
      4'd1: begin r = v >> 1; c = lo; end
      4'd3: begin r = v >> 1; r[w-1] = hi; c = lo; end
      4'd4: begin r = v << 1; r[0] = hi; c = hi; end
      4'd5: begin r = v >> 1; r[w-1] = lo; c = lo; end
      4'd6: begin r = v << 1; r[0] = cin; c = hi; end
      4'd7: begin r = v >> 1; r[w-1] = cin; c = lo; end
      4'd8: begin r = ~v; end
      default: ;
    endcase
    for (int i = w; i < 32; i++) r[i] = 1'b0;
  endtask

  task automatic run_op(input string tag, input logic [3:0] op, input logic [1:0] sz,
                        input logic [31:0] x, input logic cin);
    logic [31:0] er;
    logic ec;
    int w;
    @(negedge clk_i);
    op_i = op; size_i = sz; operand_i = x; carry_i = cin;
    @(posedge clk_i);
    #1;
    model(op, sz, x, cin, er, ec);
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    check(tag, "result", result_o, er);
    check(tag, "C", {31'd0, c_o}, {31'd0, ec});
    check("R11", "N", {31'd0, n_o}, {31'd0, er[w-1]});
    check("R11", "Z", {31'd0, z_o}, {31'd0, er == 32'd0});
    check("R12", "V", {31'd0, v_o}, 32'd0);
  endtask

  task automatic test_reset();
    check("R1", "result", result_o, 32'd0);
    check("R1", "flags", {28'd0, n_o, z_o, v_o, c_o}, 32'd0);
  endtask

  task automatic test_latency();
    // R2: output holds between edges, changes after the edge
    run_op("R2", 4'd0, 2'd2, 32'h0000_0001, 1'b0);
    @(negedge clk_i);
    op_i = 4'd1; operand_i = 32'hFFFF_FFFF;
    #2;
    check("R2", "hold before edge", result_o, 32'h0000_0002);
    @(posedge clk_i);
    #1;
    check("R2", "after edge", result_o, 32'h7FFF_FFFF);
  endtask

  task automatic sweep(input string tag, input logic [3:0] op);
    logic [31:0] pats [4] = '{32'h8000_8081, 32'h7F7F_7F7E, 32'h0000_0000, 32'h0000_0001};
    for (int s = 0; s < 3; s++)
      for (int p = 0; p < 4; p++)
        for (int ci = 0; ci < 2; ci++)
          run_op(tag, op, s[1:0], pats[p], ci[0]);
  endtask

  task automatic test_sizes();
    run_op("R3", 4'd8, 2'd0, 32'hABCD_EF12, 1'b0);
    run_op("R3", 4'd8, 2'd1, 32'hABCD_EF12, 1'b1);
    run_op("R3", 4'd0, 2'd3, 32'h8000_0001, 1'b0);
    check("R3", "size3 as long", result_o, 32'h0000_0002);
    run_op("R3", 4'd9, 2'd0, 32'hFFFF_FF80, 1'b0);
    check("R3", "byte upper bits", result_o, 32'h0000_0080);
  endtask

  task automatic test_corners();
    run_op("R6", 4'd3, 2'd0, 32'h0000_0081, 1'b0);
    check("R6", "asr byte sign", result_o, 32'h0000_00C0);
    run_op("R8", 4'd7, 2'd1, 32'h0000_0000, 1'b1);
    check("R8", "rxr word cin to top", result_o, 32'h0000_8000);
    run_op("R11", 4'd1, 2'd0, 32'h0000_0001, 1'b0);
    check("R11", "shr to zero Z", {31'd0, z_o}, 32'd1);
    run_op("R10", 4'd15, 2'd1, 32'h1234_5678, 1'b1);
    check("R10", "reserved carry", {31'd0, c_o}, 32'd1);
  endtask

  initial begin
    #1;
    test_reset();
    repeat (3) @(posedge clk_i);
    #1;
    test_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    test_latency();
    sweep("R4", 4'd0);
    sweep("R4", 4'd2);
    sweep("R5", 4'd1);
    sweep("R6", 4'd3);
    sweep("R7", 4'd4);
    sweep("R7", 4'd5);
    sweep("R8", 4'd6);
    sweep("R8", 4'd7);
    sweep("R9", 4'd8);
    sweep("R10", 4'd9);
    sweep("R10", 4'd12);
    test_sizes();
    test_corners();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule